// File: doc/BRIEF.md
# Mirrored Bit-Pair Swap-and-Compare Refresher

This controller looks after two single-bit-wide memories of eight entries that are meant to hold the same data. The two memories share one address bus and one data line. The controller walks through the addresses in turn, giving each one a fixed slot of 128 clock cycles. At 100 MHz a full walk over all eight addresses takes 1024 cycles, which is inside the 1025-cycle limit for refreshing every cell.

Within its slot, each address is refreshed by exchanging the two copies. First, memory A places its bit on the line and the controller stores it in a single holding flop. Next, memory B places its bit on the line. Memory A writes that bit, and the controller compares it with the held bit. Finally, the controller drives the held bit onto the line and memory B writes it. A cycle in which nothing drives the line separates each pair of steps.

Address and output enables change on the rising clock edge. Write strobes are active only in the second half of their cycle, so address and data are already stable while a strobe is high. When the two copies disagree, a sticky error flag is raised together with the address that failed.

Top module: `mirror_swap_refresh`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, the address is 0, all enables and strobes (`mem_a_oe`, `mem_b_oe`, `line_oe`, `mem_a_we`, `mem_b_we`) are low, and `err_flag` and `err_addr` are 0.
- R2: Count the cycles since reset was released as t, and let k = t mod 128. `mem_a_oe` is high exactly when k = 1, `mem_b_oe` exactly when k = 3, and `line_oe` exactly when k = 5. At most one of these three enables is high in any cycle.
- R3: `mem_addr` equals floor(t/128) mod 8. It advances by one at each slot boundary, wraps from 7 to 0, and completes a full walk every 1024 cycles.
- R4: `mem_a_we` is high only during the low half of the clock cycle where k = 3, and `mem_b_we` only during the low half of the cycle where k = 5. Both are low during every high half of the clock.
- R5: While `line_oe` is high, `line_out` equals the bit that memory A drove at k = 1 for the same address.
- R6: After the slot for an address has finished, memory A holds the bit that B held before the slot, and memory B holds the bit that A held before the slot.
- R7: If the bit from B at k = 3 differs from the held bit, `err_flag` is 1 and `err_addr` is that address from the next cycle on. The flag and address then stay unchanged (the first failure is kept) until a clear or a reset.
- R8: `err_clr` high in a cycle without a mismatch sets `err_flag` and `err_addr` to 0 from the next cycle on.
- R9: When a mismatch and `err_clr` fall in the same cycle, the mismatch wins: `err_flag` stays 1 and `err_addr` takes the new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| err_clr | input | 1 | Synchronous clear of the error flag and address |
| line_in | input | 1 | Value currently on the shared data line |
| mem_addr | output | 3 | Shared address for both memories |
| mem_a_oe | output | 1 | Memory A drives the data line |
| mem_b_oe | output | 1 | Memory B drives the data line |
| mem_a_we | output | 1 | Write strobe for memory A (second half of its cycle) |
| mem_b_we | output | 1 | Write strobe for memory B (second half of its cycle) |
| line_oe | output | 1 | Controller drives the data line |
| line_out | output | 1 | Bit the controller drives (held bit while `line_oe` is high, else 0) |
| err_flag | output | 1 | Sticky error flag: the two copies were found to differ |
| err_addr | output | 3 | Address of the recorded mismatch |

## Verification
The two functions that can collide are the mismatch detector and the software clear: both act on the error register at the same edge. The bench forces the collision in a directed sweep. It first makes the memories equal, then flips bit 2 of memory B only, and holds `err_clr` high through exactly the cycle at k = 3 of address 2. The result is judged by requiring the flag to stay set with address 2 (R9). Separate directed runs cover a clear with no mismatch present (R8), and faults at addresses 0 and 7 where the first failure must be kept (R7).

// File: rtl/mmr_pkg.sv
package mmr_pkg;

    // idle cycles inserted between two bus steps (line turnaround)
    localparam int STEP_GAP = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD_A = 2'd1,   // A drives, hold flop captures
        ST_XFER = 2'd2,   // B drives, A writes, compare
        ST_WR_B = 2'd3    // controller drives hold bit, B writes
    } step_e;

    typedef struct packed {
        logic a_oe;
        logic b_oe;
        logic c_oe;
        logic a_wr;
        logic b_wr;
    } bus_ctl_t;

    function automatic bus_ctl_t ctl_of(step_e s);
        bus_ctl_t c;
        c = '0;
        case (s)
            ST_RD_A: c.a_oe = 1'b1;
            ST_XFER: begin
                c.b_oe = 1'b1;
                c.a_wr = 1'b1;
            end
            ST_WR_B: begin
                c.c_oe = 1'b1;
                c.b_wr = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    // slot offset at which each step runs; offset 0 stays idle after reset
    function automatic int step_offset(step_e s);
        case (s)
            ST_RD_A: return 1;
            ST_XFER: return 1 + (1 + STEP_GAP);
            ST_WR_B: return 1 + 2 * (1 + STEP_GAP);
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/mmr_slot_timer.sv
module mmr_slot_timer #(
    parameter int ADDR_W   = 3,
    parameter int SLOT_CYC = 128,
    localparam int CNT_W   = $clog2(SLOT_CYC)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [CNT_W-1:0]  slot_cnt,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(SLOT_CYC - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_cnt <= '0;
            addr     <= '0;
        end else if (slot_cnt == SLOT_LAST) begin
            slot_cnt <= '0;
            addr     <= addr + 1'b1;
        end else begin
            slot_cnt <= slot_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mmr_step_decode.sv
module mmr_step_decode
    import mmr_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic [CNT_W-1:0] slot_cnt,
    output step_e            step,
    output bus_ctl_t         ctl
);
    localparam logic [CNT_W-1:0] OFF_RD = CNT_W'(step_offset(ST_RD_A));
    localparam logic [CNT_W-1:0] OFF_XF = CNT_W'(step_offset(ST_XFER));
    localparam logic [CNT_W-1:0] OFF_WB = CNT_W'(step_offset(ST_WR_B));

    always_comb begin
        if (slot_cnt == OFF_RD)      step = ST_RD_A;
        else if (slot_cnt == OFF_XF) step = ST_XFER;
        else if (slot_cnt == OFF_WB) step = ST_WR_B;
        else                         step = ST_IDLE;
        ctl = ctl_of(step);
    end
endmodule

// File: rtl/mmr_strobe_shaper.sv
module mmr_strobe_shaper #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] strb
);
    logic [N-1:0] half_q;

    for (genvar i = 0; i < N; i++) begin : g_strb
        // falling-edge flop opens the strobe mid-cycle; rising-edge level closes it
        always_ff @(negedge clk) begin
            if (rst) half_q[i] <= 1'b0;
            else     half_q[i] <= lvl[i];
        end
        assign strb[i] = lvl[i] & half_q[i];
    end
endmodule

// File: rtl/mmr_hold_compare.sv
module mmr_hold_compare
    import mmr_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  step_e             step,
    input  logic              line_in,
    input  logic [ADDR_W-1:0] addr,
    output logic              hold_bit,
    output logic              miss,
    output logic              err_flag,
    output logic [ADDR_W-1:0] err_addr
);
    always_ff @(posedge clk) begin
        if (rst)                  hold_bit <= 1'b0;
        else if (step == ST_RD_A) hold_bit <= line_in;
    end

    assign miss = (step == ST_XFER) && (line_in != hold_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag <= 1'b0;
            err_addr <= '0;
        end else if (miss && (!err_flag || clr)) begin
            err_flag <= 1'b1;
            err_addr <= addr;
        end else if (clr) begin
            err_flag <= 1'b0;
            err_addr <= '0;
        end
    end
endmodule

// File: rtl/mirror_swap_refresh.sv
module mirror_swap_refresh
    import mmr_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int SLOT_CYC = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              err_clr,
    input  logic              line_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_a_oe,
    output logic              mem_b_oe,
    output logic              mem_a_we,
    output logic              mem_b_we,
    output logic              line_oe,
    output logic              line_out,
    output logic              err_flag,
    output logic [ADDR_W-1:0] err_addr
);
    localparam int CNT_W = $clog2(SLOT_CYC);

    logic [CNT_W-1:0] slot_cnt;
    step_e            step;
    bus_ctl_t         ctl;
    logic [1:0]       wr_lvl;
    logic [1:0]       wr_strb;
    logic             hold_bit;
    logic             miss_now;

    mmr_slot_timer #(.ADDR_W(ADDR_W), .SLOT_CYC(SLOT_CYC)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .slot_cnt (slot_cnt),
        .addr     (mem_addr)
    );

    mmr_step_decode #(.CNT_W(CNT_W)) u_dec (
        .slot_cnt (slot_cnt),
        .step     (step),
        .ctl      (ctl)
    );

    assign wr_lvl = {ctl.b_wr, ctl.a_wr};

    mmr_strobe_shaper #(.N(2)) u_strb (
        .clk  (clk),
        .rst  (rst),
        .lvl  (wr_lvl),
        .strb (wr_strb)
    );

    mmr_hold_compare #(.ADDR_W(ADDR_W)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .clr      (err_clr),
        .step     (step),
        .line_in  (line_in),
        .addr     (mem_addr),
        .hold_bit (hold_bit),
        .miss     (miss_now),
        .err_flag (err_flag),
        .err_addr (err_addr)
    );

    assign mem_a_oe = ctl.a_oe;
    assign mem_b_oe = ctl.b_oe;
    assign line_oe  = ctl.c_oe;
    assign line_out = ctl.c_oe & hold_bit;
    assign mem_a_we = wr_strb[0];
    assign mem_b_we = wr_strb[1];
endmodule

// File: rtl/mmr_checker.sv
module mmr_checker #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              err_clr,
    input logic              miss_now,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_a_oe,
    input logic              mem_b_oe,
    input logic              mem_a_we,
    input logic              mem_b_we,
    input logic              line_oe,
    input logic              err_flag,
    input logic [ADDR_W-1:0] err_addr
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (mem_addr == '0 && !mem_a_oe && !mem_b_oe && !line_oe && !err_flag));

    p_single_driver_r2: assert property (@(posedge clk) disable iff (rst)
        $countones({mem_a_oe, mem_b_oe, line_oe}) <= 1);

    p_addr_steps_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(mem_addr) |-> (mem_addr == $past(mem_addr) + 1'b1));

    p_awrite_sourced_r4: assert property (@(posedge mem_a_we) disable iff (rst)
        mem_b_oe && !mem_a_oe && !line_oe);

    p_bwrite_sourced_r4: assert property (@(posedge mem_b_we) disable iff (rst)
        line_oe && !mem_a_oe && !mem_b_oe);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !err_clr) |=> (err_flag && $stable(err_addr)));

    p_clear_works_r8: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !miss_now) |=> !err_flag);

    p_miss_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (miss_now && err_clr) |=> (err_flag && err_addr == $past(mem_addr)));
endmodule

bind mirror_swap_refresh mmr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .err_clr  (err_clr),
    .miss_now (miss_now),
    .mem_addr (mem_addr),
    .mem_a_oe (mem_a_oe),
    .mem_b_oe (mem_b_oe),
    .mem_a_we (mem_a_we),
    .mem_b_we (mem_b_we),
    .line_oe  (line_oe),
    .err_flag (err_flag),
    .err_addr (err_addr)
);

// File: tb/mirror_swap_refresh_test.sv
module mirror_swap_refresh_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       err_clr = 1'b0;
    logic       line;
    logic [2:0] mem_addr;
    logic       mem_a_oe, mem_b_oe, mem_a_we, mem_b_we, line_oe, line_out;
    logic       err_flag;
    logic [2:0] err_addr;

    int vectors = 0;
    int fails   = 0;
    int t       = 0;
    int cycles  = 0;
    bit running = 1'b0;

    logic mem_a [8];
    logic mem_b [8];
    logic snap_a [8];
    logic snap_b [8];
    logic       exp_err = 1'b0;
    logic [2:0] exp_ea  = 3'd0;

    always #2 clk = ~clk;

    mirror_swap_refresh uut (
        .clk      (clk),
        .rst      (rst),
        .err_clr  (err_clr),
        .line_in  (line),
        .mem_addr (mem_addr),
        .mem_a_oe (mem_a_oe),
        .mem_b_oe (mem_b_oe),
        .mem_a_we (mem_a_we),
        .mem_b_we (mem_b_we),
        .line_oe  (line_oe),
        .line_out (line_out),
        .err_flag (err_flag),
        .err_addr (err_addr)
    );

    // shared line: the selected driver, otherwise pulled low
    assign line = mem_a_oe ? mem_a[mem_addr] :
                  mem_b_oe ? mem_b[mem_addr] :
                  line_oe  ? line_out : 1'b0;

    always @(posedge mem_a_we) mem_a[mem_addr] = line;
    always @(posedge mem_b_we) mem_b[mem_addr] = line;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at t=%0d", tag, what, act, exp, t);
        end
    endtask

    function automatic int offs(int tt);
        return tt % 128;
    endfunction

    function automatic int slot_addr(int tt);
        return (tt / 128) % 8;
    endfunction

    // bench timeline and expected error register
    always @(posedge clk) begin
        if (rst) begin
            t       <= 0;
            exp_err <= 1'b0;
            exp_ea  <= 3'd0;
        end else begin
            t <= t + 1;
            if (offs(t) == 3 && snap_a[slot_addr(t)] != snap_b[slot_addr(t)] &&
                (!exp_err || err_clr)) begin
                exp_err <= 1'b1;
                exp_ea  <= 3'(slot_addr(t));
            end else if (err_clr) begin
                exp_err <= 1'b0;
                exp_ea  <= 3'd0;
            end
        end
    end

    // per-cycle checks in the high half of the clock
    always @(posedge clk) begin
        #1;
        if (running && !rst) begin
            chk(mem_addr == 3'(slot_addr(t)), "R3", "mem_addr", mem_addr, slot_addr(t));
            chk(mem_a_oe == (offs(t) == 1), "R2", "mem_a_oe", mem_a_oe, offs(t) == 1);
            chk(mem_b_oe == (offs(t) == 3), "R2", "mem_b_oe", mem_b_oe, offs(t) == 3);
            chk(line_oe == (offs(t) == 5), "R2", "line_oe", line_oe, offs(t) == 5);
            chk(!mem_a_we && !mem_b_we, "R4", "strobe in high half",
                {mem_a_we, mem_b_we}, 0);
            if (offs(t) == 5)
                chk(line_out == snap_a[slot_addr(t)], "R5", "line_out",
                    line_out, snap_a[slot_addr(t)]);
            chk(err_flag == exp_err, "R7", "err_flag", err_flag, exp_err);
            chk(err_addr == exp_ea, "R7", "err_addr", err_addr, exp_ea);
        end
    end

    // strobe checks in the low half
    always @(negedge clk) begin
        #1;
        if (running && !rst) begin
            chk(mem_a_we == (offs(t) == 3), "R4", "mem_a_we", mem_a_we, offs(t) == 3);
            chk(mem_b_we == (offs(t) == 5), "R4", "mem_b_we", mem_b_we, offs(t) == 5);
        end
    end

    task automatic take_snap();
        for (int i = 0; i < 8; i++) begin
            snap_a[i] = mem_a[i];
            snap_b[i] = mem_b[i];
        end
    endtask

    task automatic wait_t(input int target);
        while (t != target) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) begin
            mem_a[i] = 1'($urandom);
            mem_b[i] = mem_a[i];
        end
        take_snap();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_addr == 3'd0, "R1", "addr in reset", mem_addr, 0);
        chk({mem_a_oe, mem_b_oe, line_oe, mem_a_we, mem_b_we} == 5'd0, "R1",
            "enables in reset", {mem_a_oe, mem_b_oe, line_oe, mem_a_we, mem_b_we}, 0);
        chk(!err_flag && err_addr == 3'd0, "R1", "error in reset", err_flag, 0);
        rst = 1'b0;
        running = 1'b1;

        for (int s = 0; s < 12; s++) begin
            wait_t(s * 1024 + 1000);
            for (int i = 0; i < 8; i++) begin
                chk(mem_a[i] == snap_b[i], "R6", $sformatf("mem_a[%0d]", i), mem_a[i], snap_b[i]);
                chk(mem_b[i] == snap_a[i], "R6", $sformatf("mem_b[%0d]", i), mem_b[i], snap_a[i]);
            end
            if (s == 8)
                chk(err_flag && err_addr == 3'd0, "R7", "first failure kept",
                    err_addr, 0);
            if (s == 3 || s == 7) begin
                for (int i = 0; i < 8; i++) mem_b[i] = mem_a[i];
                if (s == 3) mem_b[2] = ~mem_b[2];
                else begin
                    mem_b[0] = ~mem_b[0];
                    mem_b[7] = ~mem_b[7];
                end
            end else if (s != 0 && s != 5) begin
                for (int k = 0; k < int'($urandom % 3); k++) begin
                    int a = int'($urandom % 8);
                    if ($urandom % 2 == 0) mem_b[a] = ~mem_b[a];
                    else                   mem_a[a] = ~mem_a[a];
                end
            end
            take_snap();
            if (s == 5 || s == 7 || (s > 7 && $urandom % 3 == 0)) begin
                err_clr = 1'b1;
                @(negedge clk);
                err_clr = 1'b0;
                if (s == 5)
                    chk(!err_flag && err_addr == 3'd0, "R8", "flag after clear", err_flag, 0);
            end
            if (s == 3) begin
                wait_t((s + 1) * 1024 + 2 * 128 + 3);
                err_clr = 1'b1;
                @(negedge clk);
                err_clr = 1'b0;
                chk(err_flag == 1'b1, "R9", "flag after collision", err_flag, 1);
                chk(err_addr == 3'd2, "R9", "addr after collision", err_addr, 2);
            end
        end
        running = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule